// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This unit belongs to one serial channel. It holds the channel's modem control register and drives the modem control outputs from it. The DTR and RTS pins are active low. The unit also drives the enable of the channel's interrupt output and passes the automatic flow-control enable on as a level. Software writes the register through a simple write strobe, and the value it holds can always be read back.

A diagnostic loopback mode cuts the channel off from its pins:

- The serial output pin rests at idle high.
- DTR and RTS rest inactive.
- Transmit data is fed straight back into the receive path.
- The four modem input states are taken from the channel's own control bits. RTS becomes CTS, DTR becomes DSR, the first spare output becomes RI, and the inverse of the second spare output becomes CD.

In normal mode the four modem input pins pass through a two-stage synchronizer. A status byte reports the current modem states together with sticky change flags. The change flags raise a modem interrupt when that interrupt is enabled, and reading the status byte clears them.

Top module: `uart_modem_ctl`

## Requirements
- R1: `ctl_rdata_o` shows the stored control byte and resets to 0x00. Bits 7:6 are reserved: they are always stored and read as zero, whatever value is written.
- R2: Outside loopback, `dtr_n_o` is the inverse of control bit 0 and `rts_n_o` is the inverse of control bit 1. Both outputs are high after reset.
- R3: `auto_flow_o` equals control bit 5.
- R4: `irq_oe_o` equals control bit 3 in every mode. `irq_o` passes `irq_i` through unchanged.
- R5: Control bit 4 selects loopback. While loopback is active:
  - `tx_pin_o`, `dtr_n_o` and `rts_n_o` are held high.
  - `rx_ser_o` follows `tx_ser_i`.
  - `rx_pin_i` and all four modem input pins have no effect on `rx_ser_o` or on `msr_rdata_o`.
- R6: In loopback, the modem states are taken from the control register as follows:
  - CTS equals control bit 1.
  - DSR equals control bit 0.
  - RI equals control bit 2.
  - CD equals the inverse of control bit 3.
- R7: Outside loopback, `tx_pin_o` follows `tx_ser_i` and `rx_ser_o` follows `rx_pin_i`. Each modem state is the inverse of its pin and appears in `msr_rdata_o` two clock edges after the pin changes. The state bit positions are CTS = bit 4, DSR = bit 5, RI = bit 6 and CD = bit 7.
- R8: Change flags are set on the clock edge after a modem state changes, and they stay set until the status byte is read:
  - Bit 0 is set on any CTS change.
  - Bit 1 is set on any DSR change.
  - Bit 3 is set on any CD change.
  - Bit 2 is set only when RI goes from 1 to 0.
- R9: A cycle with `msr_rd_i` high clears all change flags at the next edge. A change that is detected at that same edge stays set.
- R10: `modem_irq_o` is high exactly when `modem_ie_i` is high and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read value |
| msr_rd_i | input | 1 | Status read strobe; clears the change flags |
| msr_rdata_o | output | 8 | Modem states in bits 7:4, change flags in bits 3:0 |
| tx_ser_i | input | 1 | Serial data from the transmitter |
| rx_ser_o | output | 1 | Serial data to the receiver |
| tx_pin_o | output | 1 | Serial output pin |
| rx_pin_i | input | 1 | Serial input pin |
| cts_n_i | input | 1 | CTS pin, active low |
| dsr_n_i | input | 1 | DSR pin, active low |
| ri_n_i | input | 1 | RI pin, active low |
| cd_n_i | input | 1 | CD pin, active low |
| dtr_n_o | output | 1 | DTR pin, active low |
| rts_n_o | output | 1 | RTS pin, active low |
| auto_flow_o | output | 1 | Automatic flow-control enable level |
| irq_i | input | 1 | Combined channel interrupt |
| irq_o | output | 1 | Interrupt output value |
| irq_oe_o | output | 1 | Interrupt output drive enable |
| modem_ie_i | input | 1 | Modem interrupt enable |
| modem_irq_o | output | 1 | Modem status change interrupt |

## Verification
The status read that clears the change flags can fall in the same cycle as the edge on which a new modem change is detected. The bench provokes this by first leaving a stale CTS flag set. It then drops the DSR pin and raises `msr_rd_i` exactly two edges later, so the DSR change is detected at the very edge where the read clears the flags. The result is judged correct when the stale CTS flag is gone and the fresh DSR flag remains.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int CTL_W    = 8;
  localparam int MODEM_N  = 4;
  localparam int BIT_DTR  = 0;
  localparam int BIT_RTS  = 1;
  localparam int BIT_OP1  = 2;
  localparam int BIT_OP2  = 3;
  localparam int BIT_LOOP = 4;
  localparam int BIT_AFE  = 5;
  localparam int USED_W   = BIT_AFE + 1;

  // bit order sets the status byte layout
  typedef struct packed {
    logic cd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_st_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= {WIDTH{RST_VAL}};
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import uart_modem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [USED_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (wr_i) ctl_q <= wdata_i[USED_W-1:0];
  end

  // reserved upper bits are never stored
  assign ctl_o = {{(CTL_W-USED_W){1'b0}}, ctl_q};
endmodule

// File: rtl/modem_loop_mux.sv
module modem_loop_mux
  import uart_modem_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  input  modem_st_t        pin_st_i,
  input  logic             tx_ser_i,
  input  logic             rx_pin_i,
  output logic             tx_pin_o,
  output logic             rx_ser_o,
  output logic             dtr_n_o,
  output logic             rts_n_o,
  output modem_st_t        st_o
);
  logic loop;
  modem_st_t loop_st;

  assign loop = ctl_i[BIT_LOOP];

  always_comb begin
    loop_st.cts = ctl_i[BIT_RTS];
    loop_st.dsr = ctl_i[BIT_DTR];
    loop_st.ri  = ctl_i[BIT_OP1];
    loop_st.cd  = ~ctl_i[BIT_OP2];
  end

  assign st_o     = loop ? loop_st  : pin_st_i;
  assign tx_pin_o = loop ? 1'b1     : tx_ser_i;
  assign rx_ser_o = loop ? tx_ser_i : rx_pin_i;
  assign dtr_n_o  = loop ? 1'b1     : ~ctl_i[BIT_DTR];
  assign rts_n_o  = loop ? 1'b1     : ~ctl_i[BIT_RTS];
endmodule

// File: rtl/modem_delta.sv
module modem_delta
  import uart_modem_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  modem_st_t          st_i,
  input  logic               rd_i,
  output logic [MODEM_N-1:0] delta_o
);
  modem_st_t          prev_q;
  logic [MODEM_N-1:0] delta_q;
  logic [MODEM_N-1:0] hit;

  always_comb begin
    hit[0] = st_i.cts ^ prev_q.cts;
    hit[1] = st_i.dsr ^ prev_q.dsr;
    hit[2] = prev_q.ri & ~st_i.ri;   // trailing edge only
    hit[3] = st_i.cd ^ prev_q.cd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= st_i;
      delta_q <= (rd_i ? '0 : delta_q) | hit;
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  output logic [7:0] ctl_rdata_o,
  input  logic       msr_rd_i,
  output logic [7:0] msr_rdata_o,
  input  logic       tx_ser_i,
  output logic       rx_ser_o,
  output logic       tx_pin_o,
  input  logic       rx_pin_i,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       cd_n_i,
  output logic       dtr_n_o,
  output logic       rts_n_o,
  output logic       auto_flow_o,
  input  logic       irq_i,
  output logic       irq_o,
  output logic       irq_oe_o,
  input  logic       modem_ie_i,
  output logic       modem_irq_o
);
  logic [CTL_W-1:0]   ctl;
  logic [MODEM_N-1:0] pins_n_sync;
  logic [MODEM_N-1:0] delta;
  modem_st_t          pin_st;
  modem_st_t          st;

  modem_ctl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  modem_sync #(.WIDTH(MODEM_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cd_n_i, ri_n_i, dsr_n_i, cts_n_i}),
    .q_o    (pins_n_sync)
  );

  assign pin_st = modem_st_t'(~pins_n_sync);

  modem_loop_mux u_mux (
    .ctl_i    (ctl),
    .pin_st_i (pin_st),
    .tx_ser_i (tx_ser_i),
    .rx_pin_i (rx_pin_i),
    .tx_pin_o (tx_pin_o),
    .rx_ser_o (rx_ser_o),
    .dtr_n_o  (dtr_n_o),
    .rts_n_o  (rts_n_o),
    .st_o     (st)
  );

  modem_delta u_delta (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .st_i    (st),
    .rd_i    (msr_rd_i),
    .delta_o (delta)
  );

  assign ctl_rdata_o = ctl;
  assign msr_rdata_o = {st, delta};
  assign auto_flow_o = ctl[BIT_AFE];
  assign irq_oe_o    = ctl[BIT_OP2];
  assign irq_o       = irq_i;
  assign modem_irq_o = modem_ie_i & (|delta);
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctl_rdata_o,
  input logic       msr_rd_i,
  input logic [7:0] msr_rdata_o,
  input logic       tx_ser_i,
  input logic       rx_ser_o,
  input logic       tx_pin_o,
  input logic       dtr_n_o,
  input logic       rts_n_o,
  input logic       auto_flow_o,
  input logic       irq_oe_o,
  input logic       modem_ie_i,
  input logic       modem_irq_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[7:6] == 2'b00); // R1
  AST_DTR_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[4] |-> (dtr_n_o != ctl_rdata_o[0]) && (rts_n_o != ctl_rdata_o[1])); // R2
  AST_AUTO_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_flow_o == ctl_rdata_o[5]); // R3
  AST_IRQ_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o == ctl_rdata_o[3]); // R4
  AST_LOOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[4] |-> dtr_n_o && rts_n_o && tx_pin_o); // R5
  AST_LOOP_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[4] |-> rx_ser_o == tx_ser_i); // R5
  AST_LOOP_CD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[4] |-> msr_rdata_o[7] == !ctl_rdata_o[3]); // R6
  AST_DELTA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msr_rd_i |=> (msr_rdata_o[3:0] & $past(msr_rdata_o[3:0])) == $past(msr_rdata_o[3:0])); // R8
  AST_MODEM_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modem_irq_o == (modem_ie_i && (|msr_rdata_o[3:0]))); // R10
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_rdata_o (ctl_rdata_o),
  .msr_rd_i    (msr_rd_i),
  .msr_rdata_o (msr_rdata_o),
  .tx_ser_i    (tx_ser_i),
  .rx_ser_o    (rx_ser_o),
  .tx_pin_o    (tx_pin_o),
  .dtr_n_o     (dtr_n_o),
  .rts_n_o     (rts_n_o),
  .auto_flow_o (auto_flow_o),
  .irq_oe_o    (irq_oe_o),
  .modem_ie_i  (modem_ie_i),
  .modem_irq_o (modem_irq_o)
);

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic msr_rd = 1'b0;
  logic [7:0] msr_rdata;
  logic tx_ser = 1'b1, rx_ser, tx_pin, rx_pin = 1'b1;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic dtr_n, rts_n, auto_flow, irq = 1'b0, irq_out, irq_oe;
  logic modem_ie = 1'b0, modem_irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .msr_rd_i(msr_rd), .msr_rdata_o(msr_rdata),
    .tx_ser_i(tx_ser), .rx_ser_o(rx_ser), .tx_pin_o(tx_pin), .rx_pin_i(rx_pin),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .cd_n_i(cd_n),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .auto_flow_o(auto_flow),
    .irq_i(irq), .irq_o(irq_out), .irq_oe_o(irq_oe),
    .modem_ie_i(modem_ie), .modem_irq_o(modem_irq)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic read_msr(output logic [7:0] v);
    v = msr_rdata; msr_rd = 1'b1;
    tick(1);
    msr_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "ctl reset", ctl_rdata, 8'h00);
    check("R2", "dtr/rts reset", {6'b0, dtr_n, rts_n}, 8'h03);
    check("R4", "irq_oe reset", {7'b0, irq_oe}, 8'h00);
    check("R7", "msr reset", msr_rdata, 8'h00);
  endtask

  task automatic t_loop_enter;
    logic [7:0] v;
    tx_ser = 1'b0; rx_pin = 1'b1;
    write_ctl(8'hFF);
    check("R1", "reserved bits", ctl_rdata, 8'h3F);
    check("R3", "auto flow", {7'b0, auto_flow}, 8'h01);
    check("R4", "irq_oe on", {7'b0, irq_oe}, 8'h01);
    check("R5", "loop pins idle", {5'b0, dtr_n, rts_n, tx_pin}, 8'h07);
    check("R5", "loop rx", {7'b0, rx_ser}, 8'h00);
    irq = 1'b1;
    #1 check("R4", "irq pass", {7'b0, irq_out}, 8'h01);
    tick(1);
    modem_ie = 1'b1;
    #1 check("R10", "modem irq on", {7'b0, modem_irq}, 8'h01);
    read_msr(v);
    check("R6", "loop states ff", v, 8'h73);
    check("R9", "cleared", msr_rdata, 8'h70);
    check("R10", "modem irq off", {7'b0, modem_irq}, 8'h00);
  endtask

  task automatic t_loop_ignore;
    cts_n = 1'b0; cd_n = 1'b0; rx_pin = 1'b0;
    tick(3);
    check("R5", "pins ignored msr", msr_rdata, 8'h70);
    check("R5", "rx pin ignored", {7'b0, rx_ser}, 8'h00);
    cts_n = 1'b1; cd_n = 1'b1;
    tick(3);
  endtask

  task automatic t_loop_bits;
    logic [7:0] v;
    write_ctl(8'h14);
    tick(1);
    read_msr(v);
    check("R6", "op1 ri, op2 cd", v, 8'hCB);
    write_ctl(8'h10);
    tick(1);
    read_msr(v);
    check("R8", "ri trailing", v, 8'h84);
  endtask

  task automatic t_exit;
    logic [7:0] v;
    tx_ser = 1'b0; rx_pin = 1'b0;
    write_ctl(8'h03);
    check("R2", "dtr/rts active", {6'b0, dtr_n, rts_n}, 8'h00);
    check("R4", "irq_oe off", {7'b0, irq_oe}, 8'h00);
    check("R7", "tx/rx follow", {6'b0, tx_pin, rx_ser}, 8'h00);
    tx_ser = 1'b1; rx_pin = 1'b1;
    #1 check("R7", "tx/rx follow hi", {6'b0, tx_pin, rx_ser}, 8'h03);
    tick(1);
    read_msr(v);
    check("R8", "cd change on exit", v, 8'h08);
    tick(1);
    check("R9", "clean", msr_rdata, 8'h00);
  endtask

  task automatic t_pins;
    logic [7:0] v;
    cts_n = 1'b0;
    tick(1);
    check("R7", "sync stage 1", msr_rdata, 8'h00);
    tick(1);
    check("R7", "sync stage 2", msr_rdata, 8'h10);
    tick(1);
    check("R8", "cts delta", msr_rdata, 8'h11);
    read_msr(v);
    ri_n = 1'b0;
    tick(3);
    check("R8", "ri rise no delta", msr_rdata, 8'h50);
    ri_n = 1'b1;
    tick(3);
    check("R8", "ri fall delta", msr_rdata, 8'h14);
    read_msr(v);
  endtask

  task automatic t_collide;
    cts_n = 1'b1;
    tick(3);
    check("R8", "cts fall delta", msr_rdata, 8'h01);
    dsr_n = 1'b0;
    tick(2);
    msr_rd = 1'b1;
    check("R7", "dsr visible", msr_rdata, 8'h21);
    tick(1);
    msr_rd = 1'b0;
    check("R9", "read vs new delta", msr_rdata, 8'h22);
    modem_ie = 1'b0;
    #1 check("R10", "ie low", {7'b0, modem_irq}, 8'h00);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_loop_enter();
    t_loop_ignore();
    t_loop_bits();
    t_exit();
    t_pins();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule